// File: doc/BRIEF.md
# Split Lookaside Address Translator

This block translates a virtual address into a physical one using two direct-mapped lookaside tables. One table serves instruction fetches and the other serves data loads and stores. Both tables are read at the same index, which is taken from the low bits of the virtual page number. Each entry has two 32-bit words. The tag word holds the virtual page and a valid flag. The mapping word holds the physical page and the permission bits. Software loads these words through a simple write port. A request strobe carries the address, the access kind, the privilege level and a translation enable. One cycle later the block returns the physical address, the granted rights and a fault code. The fault code separates a table miss from a protection fault.

When the physical pages of the two selected mapping words disagree, the block keeps only the entry that the access needs and treats the other as empty. The rights of the remaining entries are merged. A faulting access records its virtual address in an exception-address register. It also invalidates the load-linked reservation address by setting it to all ones. When translation is disabled, the address passes through unchanged with every right granted.

Top module: `tlbx_xlate_unit`

## Requirements
- R1: After reset every entry of both tables is invalid. The response strobe is low, the exception address is 0 and the reservation address is all ones.
- R2: The table index is virtual address bits [18:13]. A table write selects the table with `cfg_dside` (0 instruction, 1 data), the word with `cfg_xword` (0 tag, 1 mapping) and the entry with `cfg_idx`.
- R3: An entry hits only when bit 0 of its tag word is 1 and tag bits [31:13] equal virtual address bits [31:13]. An instruction hit enables execute. A data hit enables read and write.
- R4: Rights come from the mapping word according to `req_super`. Instruction execute uses bit 7 for supervisor and bit 6 for user. Data read uses bit 8 for supervisor and bit 6 for user. Data write uses bit 9 for supervisor and bit 7 for user. `rsp_rights` is {write, read, execute}, with execute at bit 0.
- R5: When translation is enabled, the physical address is the OR of both mapping words' bits [31:13], followed by virtual address bits [12:0].
- R6: If the two mapping words differ in bits [31:13], a fetch (`req_kind`=0) treats the data entry as all zero. A load (1), a store (2) or kind 3 treats the instruction entry as all zero.
- R7: A fetch needs execute, a store needs write, and other kinds need read. The fault code is 0 when the needed right is granted. Otherwise, if the entry for the needed right hit, the code is 3 for a fetch and 4 for a data access. If it did not hit, the code is 1 for a fetch and 2 for a data access.
- R8: With `xl_en` low, the response carries the virtual address as the physical address, rights 3'b111 and fault 0.
- R9: `rsp_valid` and the response fields update one cycle after `req_valid`. `rsp_valid` is low in any cycle that does not follow a request.
- R10: A response with a nonzero fault loads `exc_addr` with the request's virtual address. Successful and bypassed requests leave it unchanged.
- R11: `ll_set` loads the reservation address. A faulting request sets it to all ones and takes priority over `ll_set`. Successful requests leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xl_en | input | 1 | Translation enable |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_super | input | 1 | Supervisor privilege when 1 |
| cfg_we | input | 1 | Table word write enable |
| cfg_dside | input | 1 | 0 instruction table, 1 data table |
| cfg_xword | input | 1 | 0 tag word, 1 mapping word |
| cfg_idx | input | 6 | Entry index for writes |
| cfg_wdata | input | 32 | Word written |
| ll_set | input | 1 | Load reservation address |
| ll_set_addr | input | 32 | New reservation address |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_rights | output | 3 | Granted {write, read, execute} |
| rsp_fault | output | 3 | Fault code |
| exc_addr | output | 32 | Last faulting virtual address |
| ll_addr | output | 32 | Reservation address |

## Verification
The hardest case to reach is a disagreement between the two tables. It needs both entries at one index to be valid and tag-matching while their mapping words name different physical pages. The bench writes all four words of one index with a common tag and two different physical pages. It then issues a fetch and a load to the same address and checks the following. The fetch returns only execute and the instruction page. The load returns only read and write and the data page. Separately, the bench changes a single tag bit above the index field, and clears a single valid bit, to show a miss occurring beside a live entry at the same index.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    parameter int ADDR_W   = 32;
    parameter int PG_BITS  = 13;
    parameter int IDX_BITS = 6;
    localparam int NENT    = 1 << IDX_BITS;
    localparam int VPN_W   = ADDR_W - PG_BITS;

    // bit positions inside tag and mapping words
    localparam int VLD_BIT = 0;
    localparam int IUX_BIT = 6;
    localparam int ISX_BIT = 7;
    localparam int DUR_BIT = 6;
    localparam int DUW_BIT = 7;
    localparam int DSR_BIT = 8;
    localparam int DSW_BIT = 9;

    typedef logic [ADDR_W-1:0]   addr_t;
    typedef logic [VPN_W-1:0]    page_t;
    typedef logic [IDX_BITS-1:0] idx_t;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_OTHER = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_IMISS = 3'd1,
        FLT_DMISS = 3'd2,
        FLT_IPF   = 3'd3,
        FLT_DPF   = 3'd4
    } fault_e;

    typedef struct packed {
        logic w;
        logic r;
        logic x;
    } rights_t;

    typedef struct packed {
        addr_t tag;
        addr_t map;
    } ent_t;

    function automatic page_t page_of(input addr_t a);
        return a[ADDR_W-1:PG_BITS];
    endfunction

    function automatic rights_t need_of(input acc_kind_e k);
        rights_t n;
        n = '0;
        case (k)
            ACC_FETCH: n.x = 1'b1;
            ACC_STORE: n.w = 1'b1;
            default:   n.r = 1'b1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tlbx_table.sv
module tlbx_table
    import tlbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  logic  wsel_map,
    input  idx_t  widx,
    input  addr_t wdata,
    input  idx_t  ridx,
    output ent_t  rent
);
    logic [NENT-1:0]     vld_q;
    logic [ADDR_W-1:1]   tag_q [NENT];
    addr_t               map_q [NENT];

    // valid flags are the only state that reset must touch
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (we && !wsel_map) begin
            vld_q[widx] <= wdata[VLD_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NENT; i++) begin
                tag_q[i] <= '0;
                map_q[i] <= '0;
            end
        end else if (we) begin
            if (wsel_map) map_q[widx] <= wdata;
            else          tag_q[widx] <= wdata[ADDR_W-1:1];
        end
    end

    always_comb begin
        rent.tag = {tag_q[ridx], vld_q[ridx]};
        rent.map = map_q[ridx];
    end

    p_tag_write_r2: assert property (@(posedge clk) disable iff (rst)
        (we && !wsel_map && widx == ridx) |=> (rent.tag[VLD_BIT] == $past(wdata[VLD_BIT])));

endmodule

// File: rtl/tlbx_perm.sv
module tlbx_perm
    import tlbx_pkg::*;
(
    input  addr_t     vaddr,
    input  acc_kind_e kind,
    input  logic      super_i,
    input  ent_t      ient_i,
    input  ent_t      dent_i,
    output addr_t     paddr,
    output rights_t   grant,
    output fault_e    fault
);
    ent_t    ient, dent;
    rights_t need, hit, live;
    logic    unused_bits;

    always_comb begin
        ient = ient_i;
        dent = dent_i;
        // disagreeing physical pages: drop the side the access does not use
        if (page_of(ient_i.map) != page_of(dent_i.map)) begin
            if (kind == ACC_FETCH) dent = '0;
            else                   ient = '0;
        end

        need  = need_of(kind);
        hit.x = (page_of(ient.tag) == page_of(vaddr));
        hit.r = (page_of(dent.tag) == page_of(vaddr));
        hit.w = hit.r;

        live.x = hit.x & ient.tag[VLD_BIT];
        live.r = hit.r & dent.tag[VLD_BIT];
        live.w = live.r;

        grant.x = live.x & (super_i ? ient.map[ISX_BIT] : ient.map[IUX_BIT]);
        grant.r = live.r & (super_i ? dent.map[DSR_BIT] : dent.map[DUR_BIT]);
        grant.w = live.w & (super_i ? dent.map[DSW_BIT] : dent.map[DUW_BIT]);

        paddr = {page_of(ient.map | dent.map), vaddr[PG_BITS-1:0]};

        if (|(need & grant))     fault = FLT_NONE;
        else if (|(need & live)) fault = (kind == ACC_FETCH) ? FLT_IPF : FLT_DPF;
        else                     fault = (kind == ACC_FETCH) ? FLT_IMISS : FLT_DMISS;
    end

    assign unused_bits = ^{ient.tag[PG_BITS-1:1], dent.tag[PG_BITS-1:1],
                           ient.map[PG_BITS-1:0], dent.map[PG_BITS-1:0]};

endmodule

// File: rtl/tlbx_xlate_unit.sv
module tlbx_xlate_unit
    import tlbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        xl_en,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_kind,
    input  logic        req_super,
    input  logic        cfg_we,
    input  logic        cfg_dside,
    input  logic        cfg_xword,
    input  logic [5:0]  cfg_idx,
    input  logic [31:0] cfg_wdata,
    input  logic        ll_set,
    input  logic [31:0] ll_set_addr,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic [2:0]  rsp_rights,
    output logic [2:0]  rsp_fault,
    output logic [31:0] exc_addr,
    output logic [31:0] ll_addr
);
    localparam int NTAB = 2;

    acc_kind_e kind;
    idx_t      ridx;
    ent_t      tab_rd [NTAB];
    addr_t     p_paddr;
    rights_t   p_grant;
    fault_e    p_fault;

    rights_t   rights_q, need_q;
    fault_e    fault_q;
    logic      en_q;

    assign kind = acc_kind_e'(req_kind);
    assign ridx = req_vaddr[PG_BITS +: IDX_BITS];

    // table 0 serves fetches, table 1 serves data accesses
    for (genvar t = 0; t < NTAB; t++) begin : g_tab
        tlbx_table u_tab (
            .clk      (clk),
            .rst      (rst),
            .we       (cfg_we && (cfg_dside == (t != 0))),
            .wsel_map (cfg_xword),
            .widx     (cfg_idx),
            .wdata    (cfg_wdata),
            .ridx     (ridx),
            .rent     (tab_rd[t])
        );
    end

    tlbx_perm u_perm (
        .vaddr   (req_vaddr),
        .kind    (kind),
        .super_i (req_super),
        .ient_i  (tab_rd[0]),
        .dent_i  (tab_rd[1]),
        .paddr   (p_paddr),
        .grant   (p_grant),
        .fault   (p_fault)
    );

    logic take_fault;
    assign take_fault = req_valid && xl_en && (p_fault != FLT_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rights_q  <= '0;
            fault_q   <= FLT_NONE;
            need_q    <= '0;
            en_q      <= 1'b0;
            exc_addr  <= '0;
            ll_addr   <= '1;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                en_q   <= xl_en;
                need_q <= need_of(kind);
                if (xl_en) begin
                    rsp_paddr <= p_paddr;
                    rights_q  <= p_grant;
                    fault_q   <= p_fault;
                end else begin
                    rsp_paddr <= req_vaddr;
                    rights_q  <= '1;
                    fault_q   <= FLT_NONE;
                end
            end
            if (take_fault) begin
                exc_addr <= req_vaddr;
                ll_addr  <= '1;
            end else if (ll_set) begin
                ll_addr  <= ll_set_addr;
            end
        end
    end

    assign rsp_rights = rights_q;
    assign rsp_fault  = fault_q;

    p_rsp_timing_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_rsp_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_grant_needed_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && fault_q == FLT_NONE) |-> |(need_q & rights_q));
    p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !xl_en) |=> (rsp_paddr == $past(req_vaddr) && rsp_rights == 3'b111
                                   && rsp_fault == 3'd0));
    p_exc_capture_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && en_q && fault_q != FLT_NONE) |-> (exc_addr == $past(req_vaddr)));
    p_ll_kill_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && en_q && fault_q != FLT_NONE) |-> (ll_addr == 32'hFFFF_FFFF));

endmodule

// File: tb/tb_tlbx_xlate_unit.sv
module tb_tlbx_xlate_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        xl_en, req_valid, req_super;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        cfg_we, cfg_dside, cfg_xword;
    logic [5:0]  cfg_idx;
    logic [31:0] cfg_wdata;
    logic        ll_set;
    logic [31:0] ll_set_addr;
    logic        rsp_valid;
    logic [31:0] rsp_paddr, exc_addr, ll_addr;
    logic [2:0]  rsp_rights, rsp_fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [18:0] VPN   = 19'h12345;   // index 5
    localparam logic [18:0] PPN_A = 19'h00777;
    localparam logic [18:0] PPN_B = 19'h00888;
    localparam logic [31:0] VA    = {VPN, 13'h0ABC};
    localparam logic [9:0]  UX = 10'h040, SX = 10'h080;
    localparam logic [9:0]  UR = 10'h040, UW = 10'h080, SR = 10'h100, SW = 10'h200;

    always #4 clk = ~clk;

    tlbx_xlate_unit dut (.*);

    function automatic logic [31:0] tagw(input logic [18:0] v, input logic vld);
        return {v, 12'h000, vld};
    endfunction
    function automatic logic [31:0] mapw(input logic [18:0] p, input logic [9:0] b);
        return {p, 3'b000, b};
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic side, input logic word, input logic [5:0] idx,
                      input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dside = side; cfg_xword = word; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic req(input logic en, input logic [31:0] va, input logic [1:0] k,
                       input logic sup);
        @(negedge clk);
        xl_en = en; req_valid = 1'b1; req_vaddr = va; req_kind = k; req_super = sup;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    endtask

    task automatic set_ll(input logic [31:0] a);
        @(negedge clk);
        ll_set = 1'b1; ll_set_addr = a;
        @(negedge clk);
        ll_set = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 exc_addr", exc_addr, 32'd0);
        chk("R1 ll_addr", ll_addr, 32'hFFFF_FFFF);
        req(1'b1, VA, 2'd0, 1'b1);
        chk("R1 fetch miss", {29'd0, rsp_fault}, 32'd1);
        req(1'b1, VA, 2'd1, 1'b1);
        chk("R1 load miss", {29'd0, rsp_fault}, 32'd2);
        chk("R10 exc after miss", exc_addr, VA);
        @(negedge clk);
        chk("R9 idle", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_bypass;
        set_ll(32'h0000_0100);
        req(1'b0, 32'hDEAD_BEEF, 2'd1, 1'b0);
        chk("R8 paddr", rsp_paddr, 32'hDEAD_BEEF);
        chk("R8 rights", {29'd0, rsp_rights}, 32'd7);
        chk("R8 fault", {29'd0, rsp_fault}, 32'd0);
        chk("R10 exc held", exc_addr, VA);
        chk("R11 ll held", ll_addr, 32'h0000_0100);
    endtask

    task automatic t_hit;
        wr(1'b0, 1'b0, 6'd5, tagw(VPN, 1'b1));
        wr(1'b0, 1'b1, 6'd5, mapw(PPN_A, SX | UX));
        wr(1'b1, 1'b0, 6'd5, tagw(VPN, 1'b1));
        wr(1'b1, 1'b1, 6'd5, mapw(PPN_A, SR | SW | UR));
        req(1'b1, VA, 2'd0, 1'b1);
        chk("R5 paddr", rsp_paddr, {PPN_A, 13'h0ABC});
        chk("R3 merged rights", {29'd0, rsp_rights}, 32'd7);
        chk("R7 fetch ok", {29'd0, rsp_fault}, 32'd0);
        req(1'b1, VA, 2'd1, 1'b0);
        chk("R4 user load", {29'd0, rsp_fault}, 32'd0);
        req(1'b1, VA, 2'd2, 1'b1);
        chk("R4 super store", {29'd0, rsp_fault}, 32'd0);
        chk("R11 ll after success", ll_addr, 32'h0000_0100);
        req(1'b1, VA, 2'd2, 1'b0);
        chk("R7 user store page fault", {29'd0, rsp_fault}, 32'd4);
        chk("R4 user rights", {29'd0, rsp_rights}, 32'd3);
        chk("R11 ll killed", ll_addr, 32'hFFFF_FFFF);
        wr(1'b0, 1'b1, 6'd5, mapw(PPN_A, SX));
        req(1'b1, VA, 2'd0, 1'b0);
        chk("R7 user fetch page fault", {29'd0, rsp_fault}, 32'd3);
        chk("R4 user fetch rights", {29'd0, rsp_rights}, 32'd2);
    endtask

    task automatic t_conflict;
        wr(1'b0, 1'b1, 6'd5, mapw(PPN_A, SX | UX));
        wr(1'b1, 1'b1, 6'd5, mapw(PPN_B, SR | SW | UR | UW));
        req(1'b1, VA, 2'd0, 1'b1);
        chk("R6 fetch paddr", rsp_paddr, {PPN_A, 13'h0ABC});
        chk("R6 fetch rights", {29'd0, rsp_rights}, 32'd1);
        chk("R6 fetch fault", {29'd0, rsp_fault}, 32'd0);
        req(1'b1, VA, 2'd1, 1'b1);
        chk("R6 load paddr", rsp_paddr, {PPN_B, 13'h0ABC});
        chk("R6 load rights", {29'd0, rsp_rights}, 32'd6);
    endtask

    task automatic t_tag_index;
        wr(1'b1, 1'b1, 6'd5, mapw(PPN_A, SR | SW | UR));
        req(1'b1, {19'h12346, 13'h0ABC}, 2'd1, 1'b1);
        chk("R2 other index miss", {29'd0, rsp_fault}, 32'd2);
        wr(1'b0, 1'b0, 6'd5, tagw(VPN ^ 19'h00040, 1'b1));
        req(1'b1, VA, 2'd0, 1'b1);
        chk("R3 tag mismatch miss", {29'd0, rsp_fault}, 32'd1);
        chk("R3 tag mismatch rights", {29'd0, rsp_rights}, 32'd6);
        wr(1'b1, 1'b0, 6'd5, tagw(VPN, 1'b0));
        req(1'b1, VA, 2'd1, 1'b1);
        chk("R3 invalid miss", {29'd0, rsp_fault}, 32'd2);
        chk("R3 invalid rights", {29'd0, rsp_rights}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; xl_en = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
        req_super = 1'b0; cfg_we = 1'b0; cfg_dside = 1'b0; cfg_xword = 1'b0;
        cfg_idx = '0; cfg_wdata = '0; ll_set = 1'b0; ll_set_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bypass();
        t_hit();
        t_conflict();
        t_tag_index();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule